// File: doc/BRIEF.md
# Limb Multiply-Add Row Engine

This block works through one row of a schoolbook big-integer multiplication. A run begins with a start pulse, which latches the row length, an operating mode, the selection of operand sources, a scalar operand and an initial carry. After that, 64-bit limbs arrive least-significant first on a valid/ready stream. For each element the block forms the 128-bit sum of a product and an addend. The low half of that sum leaves on the output stream.

The block has two modes. In chain mode the upper half of each sum becomes the addend of the next element. This gives a full 64-bit carry that runs along the row, and it is reported once the row is finished. In separate mode every element uses the same fixed addend, or its own per-element addend, and the upper half of each sum is driven out beside the low half. The output then carries a complete vector of high halves.

Either multiplier operand can come from the stream or from the latched scalar. No product-plus-addend can exceed 128 bits, so the block has no overflow flag. Output backpressure stalls the carry chain, and no data is lost.

Top module: `limb_mac_row`

## Requirements
- R1: For every accepted element, `outLo` equals bits 63:0 of opA*opB + addend, computed as unsigned 128-bit arithmetic, and elements leave in the order they were accepted.
- R2: In chain mode (`cfgMode`=0), the first element's addend is `cfgCarry`. Each later element's addend is bits 127:64 of the previous element's sum. `outHi` reads zero in this mode.
- R3: In separate mode (`cfgMode`=1), `outHi` carries bits 127:64 of each element's sum. The addend is `inC` when `cfgCVec`=1 and the latched `cfgCarry` otherwise. The chain register keeps the value latched at start.
- R4: opA is `inA` when `cfgAVec`=1 and the latched `cfgScalar` otherwise. opB is `inB` when `cfgBVec`=1 and `cfgScalar` otherwise. In chain mode `inC` has no effect.
- R5: A run accepts exactly the effective length of elements, and after that `inReady` stays low. A `cfgLen` of 0 is taken as 1 and a value above 8 is taken as 8. `outLast` is high on the final element only.
- R6: While `outValid` is high and `outReady` is low, `outValid`, `outLo` and `outHi` hold their values, and no element is dropped or duplicated.
- R7: With `outReady` held high and input offered every cycle, one element is accepted per clock. A row of N elements therefore spans N+1 cycles from the first acceptance to the last output transfer.
- R8: One cycle after the last element transfers, `done` is high for exactly one cycle and `busy` has dropped. At that time `finalCarry` holds the chain register: the last upper half in chain mode, and `cfgCarry` in separate mode.
- R9: A start pulse while `busy` is high is ignored: the running row keeps its length, scalar and mode.
- R10: After reset, `busy`, `outValid`, `inReady` and `done` are low.
- R11: When all operands and the addend are all-ones, the element yields an all-zero low half and an all-ones high half, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a row; latches all cfg inputs when idle |
| cfgLen | input | 4 | Requested element count |
| cfgMode | input | 1 | 0 = chain upper halves, 1 = emit upper halves separately |
| cfgAVec | input | 1 | opA from stream (1) or scalar (0) |
| cfgBVec | input | 1 | opB from stream (1) or scalar (0) |
| cfgCVec | input | 1 | Separate mode addend from stream (1) or fixed carry (0) |
| cfgScalar | input | 64 | Scalar multiplier operand |
| cfgCarry | input | 64 | Initial carry / fixed addend |
| inValid | input | 1 | Input element present |
| inReady | output | 1 | Element will be taken at the next edge |
| inA | input | 64 | Per-element first operand |
| inB | input | 64 | Per-element second operand |
| inC | input | 64 | Per-element addend |
| outValid | output | 1 | Result element present |
| outReady | input | 1 | Consumer takes the result |
| outLo | output | 64 | Low half of the sum |
| outHi | output | 64 | High half (separate mode), zero in chain mode |
| outLast | output | 1 | Marks the final element of the row |
| busy | output | 1 | Row in progress |
| done | output | 1 | One-cycle end-of-row pulse |
| finalCarry | output | 64 | Chain register, valid with `done` |

## Verification
The assertions assume that `outReady` is the only thing that holds a result in place, and that a start pulse only takes effect while the block is idle. The bench therefore changes the stream inputs and `outReady` only at falling edges. It deliberately raises start in the middle of a row to exercise the ignore path. Stall patterns, input gaps, clamped lengths and all-ones operands all stay inside legal handshake behaviour: the bench never drops `inValid` data it has already seen accepted, and it never pulls `outValid`.

// File: rtl/limb_mac_pkg.sv
package limb_mac_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic loadCfg;   // latch configuration at row start
    logic acceptEl;  // take one input element into the output register
  } macStrobeT;
endpackage

// File: rtl/limb_mac_ctrl.sv
module limb_mac_ctrl
  import limb_mac_pkg::*;
#(
  parameter  int MAX_LEN = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast,
  output logic             busy,
  output logic             done,
  output macStrobeT        strb
);
  logic             busyQ, outValidQ, outLastQ, doneQ;
  logic [LEN_W-1:0] lenQ, cntQ, effLen, cntNext;
  logic             popOut;

  always_comb begin
    if (cfgLen == '0)                      effLen = LEN_W'(1);
    else if (cfgLen > LEN_W'(MAX_LEN))     effLen = LEN_W'(MAX_LEN);
    else                                   effLen = cfgLen;
  end

  assign cntNext      = cntQ + LEN_W'(1);
  assign inReady      = busyQ && (cntQ != lenQ) && (!outValidQ || outReady);
  assign popOut       = outValidQ && outReady;
  assign strb.loadCfg = start && !busyQ;
  assign strb.acceptEl = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      outValidQ <= 1'b0;
      outLastQ  <= 1'b0;
      doneQ     <= 1'b0;
      lenQ      <= '0;
      cntQ      <= '0;
    end else begin
      doneQ <= popOut && outLastQ;
      if (strb.loadCfg) begin
        busyQ <= 1'b1;
        lenQ  <= effLen;
        cntQ  <= '0;
      end
      if (strb.acceptEl) begin
        cntQ     <= cntNext;
        outLastQ <= (cntNext == lenQ);
      end
      if (strb.acceptEl)  outValidQ <= 1'b1;
      else if (popOut)    outValidQ <= 1'b0;
      if (popOut && outLastQ) busyQ <= 1'b0;
    end
  end

  assign outValid = outValidQ;
  assign outLast  = outLastQ;
  assign busy     = busyQ;
  assign done     = doneQ;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidQ && !outReady |=> outValidQ);
  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> cntQ <= lenQ);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ);
  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && start |=> $stable(lenQ));
endmodule

// File: rtl/limb_mac_dp.sv
module limb_mac_dp
  import limb_mac_pkg::*;
#(
  parameter  int LIMB_W = 64,
  localparam int PROD_W = 2 * LIMB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobeT         strb,
  input  logic              cfgMode,
  input  logic              cfgAVec,
  input  logic              cfgBVec,
  input  logic              cfgCVec,
  input  logic [LIMB_W-1:0] cfgScalar,
  input  logic [LIMB_W-1:0] cfgCarry,
  input  logic [LIMB_W-1:0] inA,
  input  logic [LIMB_W-1:0] inB,
  input  logic [LIMB_W-1:0] inC,
  output logic [LIMB_W-1:0] outLo,
  output logic [LIMB_W-1:0] outHi,
  output logic [LIMB_W-1:0] finalCarry
);
  logic              modeQ, aVecQ, bVecQ, cVecQ;
  logic [LIMB_W-1:0] scalarQ, fixedQ, carryQ, loQ, hiQ;
  logic [LIMB_W-1:0] opA, opB, addend;
  logic [PROD_W-1:0] sum;

  always_comb begin
    opA    = aVecQ ? inA : scalarQ;
    opB    = bVecQ ? inB : scalarQ;
    addend = modeQ ? (cVecQ ? inC : fixedQ) : carryQ;
    sum    = PROD_W'(opA) * PROD_W'(opB) + PROD_W'(addend);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      aVecQ   <= 1'b0;
      bVecQ   <= 1'b0;
      cVecQ   <= 1'b0;
      scalarQ <= '0;
      fixedQ  <= '0;
      carryQ  <= '0;
      loQ     <= '0;
      hiQ     <= '0;
    end else begin
      if (strb.loadCfg) begin
        modeQ   <= cfgMode;
        aVecQ   <= cfgAVec;
        bVecQ   <= cfgBVec;
        cVecQ   <= cfgCVec;
        scalarQ <= cfgScalar;
        fixedQ  <= cfgCarry;
        carryQ  <= cfgCarry;
      end
      if (strb.acceptEl) begin
        loQ <= sum[LIMB_W-1:0];
        hiQ <= modeQ ? sum[PROD_W-1:LIMB_W] : '0;
        if (!modeQ) carryQ <= sum[PROD_W-1:LIMB_W];
      end
    end
  end

  assign outLo      = loQ;
  assign outHi      = hiQ;
  assign finalCarry = carryQ;

  // R2
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.acceptEl && !strb.loadCfg |=> $stable(carryQ));
  // R3
  sep_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeQ && !strb.loadCfg |=> $stable(carryQ));
endmodule

// File: rtl/limb_mac_row.sv
module limb_mac_row
  import limb_mac_pkg::*;
#(
  parameter  int LIMB_W  = 64,
  parameter  int MAX_LEN = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgMode,
  input  logic              cfgAVec,
  input  logic              cfgBVec,
  input  logic              cfgCVec,
  input  logic [LIMB_W-1:0] cfgScalar,
  input  logic [LIMB_W-1:0] cfgCarry,
  input  logic              inValid,
  output logic              inReady,
  input  logic [LIMB_W-1:0] inA,
  input  logic [LIMB_W-1:0] inB,
  input  logic [LIMB_W-1:0] inC,
  output logic              outValid,
  input  logic              outReady,
  output logic [LIMB_W-1:0] outLo,
  output logic [LIMB_W-1:0] outHi,
  output logic              outLast,
  output logic              busy,
  output logic              done,
  output logic [LIMB_W-1:0] finalCarry
);
  macStrobeT strb;

  limb_mac_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgLen(cfgLen),
    .inValid(inValid), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outLast(outLast), .busy(busy), .done(done),
    .strb(strb)
  );

  limb_mac_dp #(.LIMB_W(LIMB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgMode(cfgMode),
    .cfgAVec(cfgAVec), .cfgBVec(cfgBVec), .cfgCVec(cfgCVec),
    .cfgScalar(cfgScalar), .cfgCarry(cfgCarry),
    .inA(inA), .inB(inB), .inC(inC),
    .outLo(outLo), .outHi(outHi), .finalCarry(finalCarry)
  );

  // R6
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outLo) && $stable(outHi));
endmodule

// File: tb/limb_mac_row_bench.sv
module limb_mac_row_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfgLen = '0;
  logic        cfgMode = 1'b0, cfgAVec = 1'b0, cfgBVec = 1'b0, cfgCVec = 1'b0;
  logic [63:0] cfgScalar = '0, cfgCarry = '0;
  logic        inValid = 1'b0, outReady = 1'b0;
  logic [63:0] inA = '0, inB = '0, inC = '0;
  logic        inReady, outValid, outLast, busy, done;
  logic [63:0] outLo, outHi, finalCarry;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  limb_mac_row u_limb_mac_row (
    .clk(clk), .rstN(rstN), .start(start), .cfgLen(cfgLen),
    .cfgMode(cfgMode), .cfgAVec(cfgAVec), .cfgBVec(cfgBVec), .cfgCVec(cfgCVec),
    .cfgScalar(cfgScalar), .cfgCarry(cfgCarry),
    .inValid(inValid), .inReady(inReady), .inA(inA), .inB(inB), .inC(inC),
    .outValid(outValid), .outReady(outReady), .outLo(outLo), .outHi(outHi),
    .outLast(outLast), .busy(busy), .done(done), .finalCarry(finalCarry)
  );

  typedef struct packed {
    logic        mode;
    logic        aVec;
    logic        bVec;
    logic        cVec;
    logic        stall;
    logic [3:0]  len;
    logic [63:0] scalar;
    logic [63:0] init;
    logic [15:0] seed;
  } rowT;

  localparam int NROWS = 8;
  localparam rowT ROWS [NROWS] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4,  64'h0123456789ABCDEF, 64'h0,                16'd1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8,  64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 16'd2},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  64'hDEADBEEFCAFEF00D, 64'h55,               16'd3},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5,  64'h0,                64'h7,                16'd4},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  64'h2,                64'h3,                16'd5},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15, 64'h0000000100000001, 64'h0,                16'd6},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 16'd0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2,  64'h0,                64'h0,                16'd0}
  };

  function automatic logic [63:0] genA(input logic [15:0] s, input int i);
    if (s == 16'd0) return '1;
    return ({48'b0, s} * 64'h9E3779B97F4A7C15) ^ (64'(i + 1) * 64'hD1B54A32D192ED03);
  endfunction
  function automatic logic [63:0] genB(input logic [15:0] s, input int i);
    if (s == 16'd0) return '1;
    return ({48'b0, s} * 64'hC2B2AE3D27D4EB4F) ^ (64'(i + 3) * 64'h165667B19E3779F9);
  endfunction
  function automatic logic [63:0] genC(input logic [15:0] s, input int i);
    if (s == 16'd0) return '1;
    return ({48'b0, s} * 64'h27D4EB2F165667C5) + (64'(i) * 64'h85EBCA77C2B2AE63);
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic runRow(input rowT r);
    int eLen;
    int idx;
    int got;
    int cyc;
    logic [63:0] refC;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] c;
    logic [127:0] f;
    bit stallSeen;
    bit readyChecked;
    logic [63:0] heldLo;
    eLen = (r.len == 4'd0) ? 1 : (r.len > 4'd8) ? 8 : int'(r.len);
    @(negedge clk);
    cfgLen = r.len; cfgMode = r.mode; cfgAVec = r.aVec; cfgBVec = r.bVec;
    cfgCVec = r.cVec; cfgScalar = r.scalar; cfgCarry = r.init; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; got = 0; cyc = 0; refC = r.init; stallSeen = 0; readyChecked = 0; heldLo = '0;
    while (got < eLen && cyc < 300) begin
      outReady = !(r.stall && (cyc % 3 == 1));
      inValid  = (idx < eLen) && !(r.stall && (cyc % 4 == 2));
      inA = genA(r.seed, idx); inB = genB(r.seed, idx); inC = genC(r.seed, idx);
      #1;
      if (stallSeen) begin
        check(outValid && outLo == heldLo, "R6 held data under stall", outLo, heldLo);
        stallSeen = 0;
      end
      if (idx == eLen && !readyChecked) begin
        check(inReady == 1'b0, "R5 inReady low after length reached", 64'(inReady), 64'd0);
        readyChecked = 1;
      end
      if (inValid && inReady) idx++;
      if (outValid && outReady) begin
        a = r.aVec ? genA(r.seed, got) : r.scalar;   // R4
        b = r.bVec ? genB(r.seed, got) : r.scalar;
        c = r.mode ? (r.cVec ? genC(r.seed, got) : r.init) : refC;
        f = {64'b0, a} * {64'b0, b} + {64'b0, c};
        check(outLo == f[63:0], "R1 low half", outLo, f[63:0]);
        check(outHi == (r.mode ? f[127:64] : 64'h0), r.mode ? "R3 high half" : "R2 hi zero",
              outHi, r.mode ? f[127:64] : 64'h0);
        check(outLast == (got == eLen - 1), "R5 outLast", 64'(outLast), 64'(got == eLen - 1));
        if (!r.mode) refC = f[127:64];
        got++;
      end else if (outValid) begin
        stallSeen = 1;
        heldLo = outLo;
      end
      cyc++;
      @(negedge clk);
    end
    inValid = 1'b0; outReady = 1'b1;
    #1;
    check(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
    check(busy == 1'b0, "R8 busy dropped", 64'(busy), 64'd0);
    check(finalCarry == (r.mode ? r.init : refC), "R8 finalCarry", finalCarry, r.mode ? r.init : refC);
    if (!r.stall) check(cyc == eLen + 1, "R7 one element per cycle", 64'(cyc), 64'(eLen + 1));
    @(negedge clk);
    #1;
    check(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pops;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10
    check(busy == 1'b0, "R10 busy after reset", 64'(busy), 64'd0);
    check(outValid == 1'b0, "R10 outValid after reset", 64'(outValid), 64'd0);
    check(inReady == 1'b0, "R10 inReady after reset", 64'(inReady), 64'd0);
    check(done == 1'b0, "R10 done after reset", 64'(done), 64'd0);

    // Table walk; R11 covered by rows with seed 0 (all-ones operands)
    for (int i = 0; i < NROWS; i++) runRow(ROWS[i]);

    // R9: restart attempt mid-row is ignored
    @(negedge clk);
    cfgLen = 4'd3; cfgMode = 1'b0; cfgAVec = 1'b1; cfgBVec = 1'b0; cfgCVec = 1'b0;
    cfgScalar = 64'd1; cfgCarry = 64'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pops = 0; cyc = 0;
    while (!done && cyc < 40) begin
      outReady = 1'b1;
      inValid  = 1'b1;
      inA = genA(16'd9, pops + ((outValid) ? 1 : 0));
      start = (cyc == 1);
      if (cyc == 1) begin cfgLen = 4'd8; cfgScalar = 64'd5; cfgMode = 1'b1; end
      #1;
      if (outValid && outReady) begin
        check(outLo == genA(16'd9, pops), "R9 row unchanged by restart", outLo, genA(16'd9, pops));
        pops++;
      end
      cyc++;
      @(negedge clk);
      #1;
    end
    start = 1'b0; inValid = 1'b0;
    check(pops == 3, "R9 element count kept", 64'(pops), 64'd3);
    check(done == 1'b1, "R9 row completed", 64'(done), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule